// File: doc/BRIEF.md
# Debounced Input Change-of-State Detector

This block watches four asynchronous general-purpose input pins and records which of them have changed level. Each pin first passes through a two-flop synchroniser. A slow sample-enable strobe, nominally 38.4 kHz, then samples it. A pin's level counts as changed only when two consecutive samples agree on a level that differs from the level last accepted for that pin. When that happens, a sticky per-pin change flag is set. A pulse shorter than one sample period is never seen. A pulse longer than two sample periods is always caught.

Software reads one status byte. The upper half holds the four change flags and the lower half holds the present synchronised pin levels. The read strobe clears every change flag. A per-pin enable vector selects which flags contribute to a summary status bit. A single mask bit lets that summary bit drive the interrupt output. The bus decode and the generation of the sample strobe are outside the block.

Top module: `pin_change_monitor`

## Requirements
- R1: While reset is held and on the first cycle after reset, `statusByte[7:4]`, `changeSummary` and `irqOut` are all 0.
- R2: `statusByte[3:0]` shows the level of `pinIn[3:0]` (bit i for pin i) two clock edges after the pin settles, through a two-flop synchroniser.
- R3: A change flag `statusByte[4+i]` sets at the clock edge of a `sampleTick` when this sample and the previous sample of pin i are equal and differ from the accepted reference level. The new level then becomes the reference.
- R4: A level that is present for only one sample, followed by a return to the reference, sets no flag.
- R5: Rising and falling transitions are both detected.
- R6: The first sample taken after reset loads the reference levels and sets no flag.
- R7: A cycle with `statusRead` high clears all four change flags, and the flags read 0 from the next cycle on.
- R8: A change confirmed in the same cycle as `statusRead` leaves that pin's flag set, while the other flags clear.
- R9: `changeSummary` is 1 exactly when some flag i is set while `chgEnable[i]` is 1. A flag whose enable bit is 0 has no effect on it.
- R10: `irqOut` is 1 exactly when `changeSummary` is 1 and `irqMask` is 1.
- R11: Without `sampleTick`, no flag can set, whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinIn | input | 4 | Asynchronous input pins |
| sampleTick | input | 1 | One-cycle slow sample enable |
| statusRead | input | 1 | Read strobe for the status byte; clears the flags |
| chgEnable | input | 4 | Per-pin enable into the summary bit |
| irqMask | input | 1 | Interrupt mask; 1 lets the summary drive `irqOut` |
| statusByte | output | 8 | {change flags[3:0], synchronised pin levels[3:0]} |
| changeSummary | output | 1 | OR of the enabled change flags |
| irqOut | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: a clear-on-read and a newly confirmed change. The bench provokes this by giving pin 3 one sample at its new level and then asserting `statusRead` together with the second, confirming `sampleTick`, while the flag of an older change is still set. The correct result is that the older flag clears and pin 3's flag remains, so the status upper nibble reads 4'b1000. A behavioural reference model compares every output on every clock.

// File: rtl/pin_change_pkg.sv
package pin_change_pkg;
  typedef struct packed {
    logic takeSample;  // a slow sample is taken this cycle
    logic primeRef;    // first sample after reset: load reference only
    logic clearFlags;  // status byte is being read
  } chgCtrl_t;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pcm_ctrl.sv
module pcm_ctrl
  import pin_change_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sampleTick,
  input  logic     statusRead,
  output chgCtrl_t strobes
);
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          primed <= 1'b0;
    else if (sampleTick) primed <= 1'b1;
  end

  always_comb begin
    strobes.takeSample = sampleTick;
    strobes.primeRef   = sampleTick & ~primed;
    strobes.clearFlags = statusRead;
  end
endmodule

// File: rtl/pcm_datapath.sv
module pcm_datapath
  import pin_change_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  chgCtrl_t            strobes,
  input  logic [NUM_PINS-1:0] chgEnable,
  output logic [NUM_PINS-1:0] flags,
  output logic [NUM_PINS-1:0] pinLevel,
  output logic                summary
);
  logic [NUM_PINS-1:0] prevSample;
  logic [NUM_PINS-1:0] refLevel;
  logic [NUM_PINS-1:0] confirm;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sync
    pcm_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .asyncIn(pinIn[i]),
      .syncOut(pinLevel[i])
    );
  end

  // Two agreeing samples that both differ from the accepted level
  always_comb begin
    if (strobes.takeSample && !strobes.primeRef)
      confirm = ~(pinLevel ^ prevSample) & (pinLevel ^ refLevel);
    else
      confirm = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevSample <= '0;
      refLevel   <= '0;
      flags      <= '0;
    end else begin
      if (strobes.takeSample) begin
        prevSample <= pinLevel;
        refLevel   <= strobes.primeRef ? pinLevel : (refLevel ^ confirm);
      end
      flags <= (strobes.clearFlags ? '0 : flags) | confirm;
    end
  end

  assign summary = |(flags & chgEnable);
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor
  import pin_change_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int STATUS_W   = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                sampleTick,
  input  logic                statusRead,
  input  logic [NUM_PINS-1:0] chgEnable,
  input  logic                irqMask,
  output logic [STATUS_W-1:0] statusByte,
  output logic                changeSummary,
  output logic                irqOut
);
  chgCtrl_t            strobes;
  logic [NUM_PINS-1:0] flags;
  logic [NUM_PINS-1:0] pinLevel;

  pcm_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sampleTick(sampleTick),
    .statusRead(statusRead),
    .strobes   (strobes)
  );

  pcm_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinIn    (pinIn),
    .strobes  (strobes),
    .chgEnable(chgEnable),
    .flags    (flags),
    .pinLevel (pinLevel),
    .summary  (changeSummary)
  );

  assign statusByte = {flags, pinLevel};
  assign irqOut     = changeSummary & irqMask;
endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
  parameter int NUM_PINS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sampleTick,
  input logic                  statusRead,
  input logic                  irqMask,
  input logic [2*NUM_PINS-1:0] statusByte,
  input logic                  changeSummary,
  input logic                  irqOut
);
  logic [NUM_PINS-1:0] flagsSeen;
  assign flagsSeen = statusByte[2*NUM_PINS-1:NUM_PINS];

  // R7: a read with no sample in the same cycle leaves no flag set
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRead && !sampleTick) |=> (flagsSeen == '0));

  // R11: with neither a sample nor a read, the flags hold
  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleTick && !statusRead) |=> $stable(flagsSeen));

  // R3: a newly set flag always follows a sample strobe
  assert_set_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flagsSeen & ~$past(flagsSeen)) != '0) |-> $past(sampleTick));

  // R9: the summary bit needs at least one flag set
  assert_summary_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    changeSummary |-> (flagsSeen != '0));

  // R10: no interrupt while masked
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (irqMask && changeSummary));
endmodule

bind pin_change_monitor pcm_checker #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sampleTick   (sampleTick),
  .statusRead   (statusRead),
  .irqMask      (irqMask),
  .statusByte   (statusByte),
  .changeSummary(changeSummary),
  .irqOut       (irqOut)
);

// File: tb/pin_change_monitor_tb.sv
module pin_change_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pinIn = 4'b0101;
  logic       sampleTick = 1'b0;
  logic       statusRead = 1'b0;
  logic [3:0] chgEnable = 4'b0000;
  logic       irqMask = 1'b0;
  logic [7:0] statusByte;
  logic       changeSummary;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  pin_change_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .sampleTick(sampleTick),
    .statusRead(statusRead), .chgEnable(chgEnable), .irqMask(irqMask),
    .statusByte(statusByte), .changeSummary(changeSummary), .irqOut(irqOut)
  );

  // Behavioural reference model
  logic [3:0] mSyncA, mSyncB, mPrev, mRef, mFlags;
  bit         mPrimed;

  always @(posedge clk) begin
    if (!rst_n) begin
      mSyncA = 0; mSyncB = 0; mPrev = 0; mRef = 0; mFlags = 0; mPrimed = 0;
    end else begin
      logic [3:0] conf;
      conf = 4'b0000;
      if (sampleTick) begin
        if (!mPrimed) begin
          mRef = mSyncB;
          mPrimed = 1;
        end else begin
          for (int i = 0; i < 4; i++)
            if (mSyncB[i] == mPrev[i] && mSyncB[i] != mRef[i]) begin
              conf[i] = 1'b1;
              mRef[i] = mSyncB[i];
            end
        end
        mPrev = mSyncB;
      end
      mFlags = (statusRead ? 4'b0000 : mFlags) | conf;
      mSyncB = mSyncA;
      mSyncA = pinIn;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic sumExp;
      sumExp = |(mFlags & chgEnable);
      check("R3 flags vs model", {4'h0, statusByte[7:4]}, {4'h0, mFlags});
      check("R2 pin levels vs model", {4'h0, statusByte[3:0]}, {4'h0, mSyncB});
      check("R9 summary vs model", {7'h0, changeSummary}, {7'h0, sumExp});
      check("R10 irq vs model", {7'h0, irqOut}, {7'h0, sumExp & irqMask});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(bit rd = 0);
    sampleTick = 1'b1; statusRead = rd;
    @(negedge clk);
    sampleTick = 1'b0; statusRead = 1'b0;
    #1;
  endtask

  task automatic readStatus();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(5);
    #1;
    check("R1 reset flags", {4'h0, statusByte[7:4]}, 8'h00);
    check("R1 reset summary/irq", {6'h0, changeSummary, irqOut}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 first cycle flags", {4'h0, statusByte[7:4]}, 8'h00);
    cyc(3); #1;
    check("R2 synchronised levels", {4'h0, statusByte[3:0]}, 8'h05);

    tick();  // priming sample
    cyc(2); #1;
    check("R6 no flag from first sample", {4'h0, statusByte[7:4]}, 8'h00);

    pinIn = 4'b0100; cyc(3);
    tick();
    check("R3 one sample not enough", {4'h0, statusByte[7:4]}, 8'h00);
    tick();
    check("R5 falling edge confirmed", {4'h0, statusByte[7:4]}, 8'h01);

    pinIn = 4'b0110; cyc(12); #1;
    check("R11 no tick no flag", {4'h0, statusByte[7:4]}, 8'h01);

    readStatus();
    check("R7 read clears flags", {4'h0, statusByte[7:4]}, 8'h00);

    tick(); tick();
    check("R5 rising edge confirmed", {4'h0, statusByte[7:4]}, 8'h02);

    pinIn = 4'b1110; cyc(3);
    tick();
    pinIn = 4'b0110; cyc(3);
    tick(); tick();
    check("R4 single-sample glitch ignored", {4'h0, statusByte[7:4]}, 8'h02);

    pinIn = 4'b1110; cyc(3);
    tick();
    tick(1'b1);  // confirming sample together with a read
    check("R8 confirm wins over read", {4'h0, statusByte[7:4]}, 8'h08);

    cyc(1); #1;
    check("R9 disabled flag ignored", {7'h0, changeSummary}, 8'h00);
    chgEnable = 4'b1000; cyc(1); #1;
    check("R9 enabled flag drives summary", {7'h0, changeSummary}, 8'h01);
    check("R10 masked irq low", {7'h0, irqOut}, 8'h00);
    irqMask = 1'b1; cyc(1); #1;
    check("R10 unmasked irq high", {7'h0, irqOut}, 8'h01);
    chgEnable = 4'b0111; cyc(1); #1;
    check("R9 other enables only", {7'h0, changeSummary}, 8'h00);
    chgEnable = 4'b1111;
    readStatus();
    check("R7 read drops summary and irq", {6'h0, changeSummary, irqOut}, 8'h00);

    cyc(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule